// File: doc/BRIEF.md
# Bit-Serial Ternary Search Array

This block is a row of one-bit processing elements run by one shared sequencer. Each element keeps a private word in a register. The words are written one at a time through a load port. A search command carries a key and a care mask. The sequencer latches both and sends the same key bit and care bit to every element on each clock, starting at the most significant bit and ending at the least significant bit.

Every element keeps a match flag. The flag is set to one when the search is accepted. On each bit clock the flag is cleared if the care bit is one and the key bit differs from the element's stored bit. A care bit of zero makes that position a wildcard. Combined with the key bit, this gives three conditions per position: the stored bit must be one, the stored bit must be zero, or the position is ignored.

When the last bit has been processed, the flags feed an adder tree. A registered total and a registered any-hit flag return to the requester, together with a one-cycle done pulse. Both results are held unchanged until the next search completes.

The sequencer has three states:
- ST_IDLE waits for a command. An accepted command moves it to ST_SCAN.
- ST_SCAN steps through the bits. When bit 0 has been processed it moves to ST_TALLY.
- ST_TALLY captures the results and always returns to ST_IDLE.

Top module: `assoc_search_array`

## Requirements
- R1: When `busy` is low, a pulse on `ld_en` writes `ld_data` into the element selected by `ld_addr`, where element i has index i.
- R2: An element matches when its stored word equals the key at every bit position whose care bit is 1 (bit i of `srch_care` governs bit i of the word). Positions whose care bit is 0 never affect the result.
- R3: After a search, `hit_count` equals the number of matching elements, and `any_hit` is 1 exactly when `hit_count` is nonzero.
- R4: When no element matches, `any_hit` is 0 and `hit_count` is 0. When several elements match, all of them are counted.
- R5: A search is accepted when `srch_start` is seen high on a rising edge while `busy` is low. `busy` is then high for exactly WORD_W+1 cycles. `done` is high for exactly one cycle, the first cycle in which `busy` is low again, and the results are valid in that same cycle.
- R6: `srch_start` is ignored while `busy` is high. It does not change the result or the timing of the search in progress.
- R7: `ld_en` is ignored while `busy` is high. The stored words are left unchanged.
- R8: `hit_count` and `any_hit` change only in a cycle where `done` is high. Between searches they stay steady, even when the key and mask inputs change.
- R9: After reset, `busy`, `done`, `any_hit` and `hit_count` are all 0, and the sequencer is in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write enable for one element word |
| ld_addr | input | $clog2(NUM_PE) | Index of the element to write |
| ld_data | input | WORD_W | Word to store |
| srch_start | input | 1 | Search request |
| srch_key | input | WORD_W | Key to compare against |
| srch_care | input | WORD_W | Per-bit care mask: 1 compares the bit, 0 makes it a wildcard |
| busy | output | 1 | High while a search is running |
| done | output | 1 | One-cycle pulse when the results are updated |
| any_hit | output | 1 | At least one element matched |
| hit_count | output | $clog2(NUM_PE+1) | Number of matching elements |

## Verification
A flag that is set wrongly at the start of a search, or updated at the wrong bit index, gives a wrong `hit_count` in the done cycle of that same search. The exhaustive sweep over key and mask on a small array exposes this on the first affected combination. A fault in the sequencer's counter or state shows as a busy window of the wrong length or a misplaced done pulse, and it is visible in the very first search. A corrupted result register shows as a count that changes while `done` is low, or an `any_hit` that disagrees with a zero or nonzero count, on the next clock.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_TALLY
    } ctrl_state_e;
endpackage

// File: rtl/assoc_pe.sv
// One bit-serial processing element: stored word plus a running match flag.
module assoc_pe #(
    parameter int WORD_W = 8,
    localparam int IW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              preset,
    input  logic              step,
    input  logic [IW-1:0]     bit_idx,
    input  logic              key_bit,
    input  logic              care_bit,
    output logic              hit
);
    logic [WORD_W-1:0] word_q;
    logic              bit_ok;

    assign bit_ok = ~care_bit | (key_bit ~^ word_q[bit_idx]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else if (preset) begin
            hit <= 1'b1;
        end else if (step) begin
            hit <= hit & bit_ok;
        end
    end
endmodule

// File: rtl/assoc_popcount.sv
// Adder tree over the element flags, laid out as a heap: node k sums 2k+1 and 2k+2.
module assoc_popcount #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1),
    localparam int P = 1 << $clog2(N)
) (
    input  logic [N-1:0]  flags,
    output logic [CW-1:0] total
);
    logic [CW-1:0] node [2*P-1];

    for (genvar i = 0; i < P; i++) begin : g_leaf
        if (i < N) begin : g_real
            assign node[P-1+i] = {{(CW-1){1'b0}}, flags[i]};
        end else begin : g_pad
            assign node[P-1+i] = '0;
        end
    end

    for (genvar k = 0; k < P-1; k++) begin : g_sum
        assign node[k] = node[2*k+1] + node[2*k+2];
    end

    assign total = node[0];
endmodule

// File: rtl/assoc_ctrl.sv
// Sequencer: accepts a search, walks the bit index MSB to LSB, then tallies.
module assoc_ctrl
    import assoc_pkg::*;
#(
    parameter int WORD_W = 8,
    localparam int IW = $clog2(WORD_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_req,
    output logic          busy,
    output logic          accept,
    output logic          step,
    output logic          capture,
    output logic [IW-1:0] bit_idx
);
    localparam logic [IW-1:0] LAST = IW'(WORD_W - 1);

    ctrl_state_e state_q, state_d;
    logic [IW-1:0] idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_req)      state_d = ST_SCAN;
            ST_SCAN:  if (idx_q == '0)    state_d = ST_TALLY;
            ST_TALLY:                     state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                idx_q <= LAST;
            end else if (step && idx_q != '0) begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy    = 1'b0;
        accept  = 1'b0;
        step    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept  = start_req;
            ST_SCAN:  begin busy = 1'b1; step = 1'b1; end
            ST_TALLY: begin busy = 1'b1; capture = 1'b1; end
            default:  ;
        endcase
    end

    assign bit_idx = idx_q;
endmodule

// File: rtl/assoc_search_array.sv
module assoc_search_array #(
    parameter int NUM_PE = 8,
    parameter int WORD_W = 8,
    localparam int AW = $clog2(NUM_PE),
    localparam int CW = $clog2(NUM_PE + 1),
    localparam int IW = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              srch_start,
    input  logic [WORD_W-1:0] srch_key,
    input  logic [WORD_W-1:0] srch_care,
    output logic              busy,
    output logic              done,
    output logic              any_hit,
    output logic [CW-1:0]     hit_count
);
    logic              busy_w, accept, step, capture;
    logic [IW-1:0]     bit_idx;
    logic [WORD_W-1:0] key_q, care_q;
    logic [NUM_PE-1:0] flags;
    logic [CW-1:0]     tally;

    assoc_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (srch_start),
        .busy      (busy_w),
        .accept    (accept),
        .step      (step),
        .capture   (capture),
        .bit_idx   (bit_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            care_q <= '0;
        end else if (accept) begin
            key_q  <= srch_key;
            care_q <= srch_care;
        end
    end

    for (genvar i = 0; i < NUM_PE; i++) begin : g_pe
        assoc_pe #(.WORD_W(WORD_W)) u_pe (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (ld_en && !busy_w && (ld_addr == AW'(i))),
            .wr_data  (ld_data),
            .preset   (accept),
            .step     (step),
            .bit_idx  (bit_idx),
            .key_bit  (key_q[bit_idx]),
            .care_bit (care_q[bit_idx]),
            .hit      (flags[i])
        );
    end

    assoc_popcount #(.N(NUM_PE), .CW(CW)) u_tree (
        .flags (flags),
        .total (tally)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_count <= '0;
            any_hit   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= capture;
            if (capture) begin
                hit_count <= tally;
                any_hit   <= |flags;
            end
        end
    end

    assign busy = busy_w;
endmodule

// File: rtl/assoc_search_array_chk.sv
module assoc_search_array_chk #(
    parameter int NUM_PE = 8,
    parameter int WORD_W = 8,
    localparam int CW = $clog2(NUM_PE + 1),
    localparam int LW = $clog2(WORD_W + 3)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          any_hit,
    input logic [CW-1:0] hit_count
);
    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!busy) begin
            run_len <= '0;
        end else if (run_len != {LW{1'b1}}) begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == LW'(WORD_W + 1)));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_any_vs_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit == (hit_count != '0));

    assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= CW'(NUM_PE));

    assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hit_count) && $stable(any_hit)));
endmodule

bind assoc_search_array assoc_search_array_chk #(
    .NUM_PE (NUM_PE),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .any_hit   (any_hit),
    .hit_count (hit_count)
);

// File: tb/assoc_search_array_bench.sv
`timescale 1ns/1ps
module assoc_search_array_bench;
    localparam int NPE = 8;
    localparam int W   = 4;
    localparam int AW  = $clog2(NPE);
    localparam int CW  = $clog2(NPE + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [W-1:0]  ld_data = '0;
    logic          srch_start = 1'b0;
    logic [W-1:0]  srch_key = '0;
    logic [W-1:0]  srch_care = '0;
    logic          busy, done, any_hit;
    logic [CW-1:0] hit_count;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] model [NPE];

    always #2.5 clk = ~clk;

    assoc_search_array #(.NUM_PE(NPE), .WORD_W(W)) u_assoc_search_array (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr),
        .ld_data(ld_data), .srch_start(srch_start), .srch_key(srch_key),
        .srch_care(srch_care), .busy(busy), .done(done),
        .any_hit(any_hit), .hit_count(hit_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_hits(input logic [W-1:0] key, input logic [W-1:0] care);
        int n = 0;
        for (int i = 0; i < NPE; i++)
            if (((model[i] ^ key) & care) == '0) n++;
        return n;
    endfunction

    task automatic load_word(input int addr, input logic [W-1:0] data);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = AW'(addr); ld_data = data;
        @(negedge clk);
        ld_en = 1'b0;
        model[addr] = data;
    endtask

    // mode 0: plain; 1: extra start while busy (R6); 2: load while busy (R7)
    task automatic run_search(input logic [W-1:0] key, input logic [W-1:0] care, input int mode);
        int exp;
        exp = expect_hits(key, care);
        @(negedge clk);
        srch_start = 1'b1; srch_key = key; srch_care = care;
        @(negedge clk);
        srch_start = 1'b0;
        for (int c = 0; c <= W; c++) begin
            srch_start = 1'b0;
            ld_en = 1'b0;
            check(busy == 1'b1 && done == 1'b0, "R5 busy window", int'({busy, done}), 2);
            if (c == 1 && mode == 1) begin
                srch_start = 1'b1; srch_key = ~key; srch_care = '1;
            end
            if (c == 1 && mode == 2) begin
                ld_en = 1'b1; ld_addr = '0; ld_data = ~model[0];
            end
            @(negedge clk);
        end
        srch_start = 1'b0;
        ld_en = 1'b0;
        check(busy == 1'b0 && done == 1'b1, "R5 done pulse", int'({busy, done}), 1);
        check(int'(hit_count) == exp, "R2/R3 hit_count", int'(hit_count), exp);
        check(any_hit == (exp != 0), "R3/R4 any_hit", int'(any_hit), int'(exp != 0));
    endtask

    task automatic sweep();
        for (int k = 0; k < (1 << W); k++)
            for (int m = 0; m < (1 << W); m++)
                run_search(W'(k), W'(m), 0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int held;
        for (int i = 0; i < NPE; i++) model[i] = '0;
        repeat (4) @(negedge clk);
        // R9: reset state
        check(busy == 1'b0, "R9 busy", int'(busy), 0);
        check(done == 1'b0, "R9 done", int'(done), 0);
        check(any_hit == 1'b0, "R9 any_hit", int'(any_hit), 0);
        check(hit_count == '0, "R9 hit_count", int'(hit_count), 0);
        rst_n = 1'b1;

        // R1: distinct odd words, then full ternary sweep (R2, R3)
        for (int i = 0; i < NPE; i++) load_word(i, W'(2*i + 1));
        sweep();
        // R4: no element matches (all words odd, key asks LSB = 0)
        run_search(4'b0000, 4'b0001, 0);
        check(hit_count == '0 && any_hit == 1'b0, "R4 none match", int'(hit_count), 0);

        // R1/R4: duplicate words, several matches
        load_word(0, 4'h5); load_word(1, 4'h5); load_word(2, 4'h5); load_word(3, 4'h0);
        load_word(4, 4'hF); load_word(5, 4'h5); load_word(6, 4'hA); load_word(7, 4'h0);
        sweep();
        run_search(4'h5, 4'hF, 0);
        check(int'(hit_count) == 4, "R4 several match", int'(hit_count), 4);

        // R6: start while busy ignored
        run_search(4'hA, 4'hF, 1);
        check(int'(hit_count) == 1, "R6 restart ignored", int'(hit_count), 1);

        // R7: load while busy ignored; word 0 must still be 5
        run_search(4'h5, 4'hF, 2);
        run_search(4'h5, 4'hF, 0);
        check(int'(hit_count) == 4, "R7 load ignored", int'(hit_count), 4);

        // R8: results held while idle and inputs wiggle
        held = int'(hit_count);
        for (int c = 0; c < 5; c++) begin
            srch_key = W'(c); srch_care = '1;
            @(negedge clk);
            check(int'(hit_count) == held && any_hit == 1'b1 && done == 1'b0,
                  "R8 results held", int'(hit_count), held);
        end
        finish_run();
    end
endmodule